// File: doc/BRIEF.md
# Compressed RISC-V Instruction Decoder

This block turns one 16-bit RISC-V compressed instruction into a uniform decoded form: an operation code, destination and source register indices, a fully assembled 32-bit immediate, and an illegal flag. A halfword offered with `in_valid` high is decoded combinationally and captured in an output register, so the result shows up one clock later with `out_valid` high. While `in_valid` is low the output register keeps its last contents.

The base width is an elaboration parameter, `XLEN` (32 or 64). Several encodings change meaning with it. On the wider base, the single-precision load/store slots become doubleword integer loads and stores, and the jump-and-link slot becomes a word add-immediate. Three-bit register fields address x8 to x15. Each immediate is rebuilt from the bit scatter of its own format.

Floating-point encodings are reported as recognised operations with their offsets and register fields, and are not executed. Register reads, execution, program-counter update and memory access belong to neighbouring blocks.

Top module: `rvc_decoder`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `in_valid` high and low otherwise. While `in_valid` is low, `out_op`, the register indices, `out_imm` and `out_illegal` keep their values.
- R2: The quadrant is bits [1:0] and the major function is bits [15:13]. Each of the following raises `out_illegal` with `out_op` = OPC_ILLEGAL and rd, rs1, rs2 and imm all zero: quadrant 3, the all-zero halfword, and quadrant 0 with major function 100.
- R3: A 3-bit register field at bits [9:7] or [4:2] selects x8 plus its value.
- R4: In quadrant 1, major function 100, bits [11:10] choose the operation: 00 shift right logical, 01 shift right arithmetic, 10 AND-immediate, 11 register arithmetic. Within register arithmetic, bits [6:5] = 00/01/10/11 give SUB/XOR/OR/AND when bit 12 is 0. With bit 12 = 1, 00 gives SUBW and 01 gives ADDW. In all of these rd equals rs1.
- R5: In quadrant 2, major function 100, the decoder chooses as follows. With bit 12 = 0 it gives JR when bits [6:2] are zero and MV otherwise. With bit 12 = 1 it gives EBREAK when bits [11:2] are zero, JALR when only bits [6:2] are zero, and ADD otherwise.
- R6: With XLEN = 64 the encodings decode as follows: quadrant 0 functions 011/111 give LD/SD with doubleword offsets, quadrant 1 function 001 gives ADDIW, and quadrant 2 functions 011/111 give LDSP/SDSP. With XLEN = 32 the same slots give FLW/FSW, JAL, FLWSP and FSWSP with word offsets.
- R7: The stack-pointer add-immediate (quadrant 0, function 000) yields a zero-extended immediate with bits [9:6] from [10:7], bits [5:4] from [12:11], bit 3 from bit 5 and bit 2 from bit 6. An immediate of zero is illegal.
- R8: In quadrant 1, function 011, rd = 2 decodes ADDI16SP with a 10-bit sign-extended immediate. Any other rd decodes LUI, whose immediate has bit 17 from bit 12 and bits [16:12] from [6:2], sign-extended.
- R9: The 6-bit immediate {bit 12, bits [6:2]} is sign-extended for ADDI, ADDIW, LI and ANDI. For the three shifts it is zero-extended. On XLEN = 32 a shift with bit 12 set is illegal.
- R10: The branch-if-zero offsets are 9-bit and sign-extended, and the jump offsets are 12-bit and sign-extended. Bit 0 of every branch or jump offset is zero.
- R11: Load/store offsets are zero-extended and scaled by the access size. Word offsets are multiples of 4 up to 124 for register-based accesses and 252 for stack-based accesses. Doubleword offsets are multiples of 8 up to 248 and 504 respectively.
- R12: LWSP with rd = x0 is illegal. On XLEN = 64, LDSP with rd = x0 is also illegal.
- R13: Implied registers: stack-based forms report rs1 = x2. JAL and JALR report rd = x1. J, JR, branches and stores report rd = x0. LI, LUI and MV report rs1 = x0.
- R14: During and right after reset, `out_valid` and `out_illegal` are 0 and `out_op` is OPC_ILLEGAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Halfword strobe |
| in_half | input | 16 | Compressed instruction |
| out_valid | output | 1 | Decoded result valid |
| out_op | output | 6 | Operation code (package enumeration) |
| out_rd | output | 5 | Destination register index |
| out_rs1 | output | 5 | First source register index |
| out_rs2 | output | 5 | Second source register index |
| out_imm | output | 32 | Assembled immediate |
| out_illegal | output | 1 | Encoding is reserved or illegal |

## Verification
The assertions assume that `in_half` is meaningful only in cycles where `in_valid` is high. They also assume that the payload hold after an idle cycle is judged only against the previously captured result. The stimulus drives inputs on the falling edge, holds each halfword for one full cycle, and inserts idle gaps so the hold behaviour is exercised. Halfwords are composed from quadrant, function and field values, and both base widths decode the same stream side by side so that width-dependent slots are compared directly.

// File: rtl/rvc_dec_pkg.sv
package rvc_dec_pkg;

  localparam int HALF_W = 16;
  localparam int IMM_W  = 32;
  localparam int REG_W  = 5;
  localparam int OP_W   = 6;

  localparam logic [REG_W-1:0] REG_ZERO = 5'd0;
  localparam logic [REG_W-1:0] REG_LINK = 5'd1;
  localparam logic [REG_W-1:0] REG_SP   = 5'd2;

  typedef enum logic [OP_W-1:0] {
    OPC_ILLEGAL, OPC_ADDI4SPN, OPC_FLD, OPC_LW, OPC_FLW, OPC_LD, OPC_FSD,
    OPC_SW, OPC_FSW, OPC_SD, OPC_ADDI, OPC_JAL, OPC_ADDIW, OPC_LI,
    OPC_ADDI16SP, OPC_LUI, OPC_SRLI, OPC_SRAI, OPC_ANDI, OPC_SUB, OPC_XOR,
    OPC_OR, OPC_AND, OPC_SUBW, OPC_ADDW, OPC_J, OPC_BEQZ, OPC_BNEZ,
    OPC_SLLI, OPC_FLDSP, OPC_LWSP, OPC_FLWSP, OPC_LDSP, OPC_JR, OPC_MV,
    OPC_EBREAK, OPC_JALR, OPC_ADD, OPC_FSDSP, OPC_SWSP, OPC_FSWSP, OPC_SDSP
  } rvc_op_e;

  typedef enum logic [3:0] {
    IMF_NONE, IMF_SPADD, IMF_MEMW, IMF_MEMD, IMF_SMALL, IMF_SHAMT, IMF_UPPER,
    IMF_SPADJ, IMF_BRANCH, IMF_JUMP, IMF_SPLDW, IMF_SPLDD, IMF_SPSTW, IMF_SPSTD
  } imm_fmt_e;

  function automatic logic [REG_W-1:0] narrow_reg(input logic [2:0] f);
    return {2'b01, f};
  endfunction

  function automatic logic [IMM_W-1:0] imm_spadd(input logic [HALF_W-1:0] h);
    return {22'd0, h[10:7], h[12:11], h[5], h[6], 2'b00};
  endfunction

  function automatic logic [IMM_W-1:0] imm_memw(input logic [HALF_W-1:0] h);
    return {25'd0, h[5], h[12:10], h[6], 2'b00};
  endfunction

  function automatic logic [IMM_W-1:0] imm_memd(input logic [HALF_W-1:0] h);
    return {24'd0, h[6:5], h[12:10], 3'b000};
  endfunction

  function automatic logic [IMM_W-1:0] imm_small(input logic [HALF_W-1:0] h);
    return {{26{h[12]}}, h[12], h[6:2]};
  endfunction

  function automatic logic [IMM_W-1:0] imm_shamt(input logic [HALF_W-1:0] h);
    return {26'd0, h[12], h[6:2]};
  endfunction

  function automatic logic [IMM_W-1:0] imm_upper(input logic [HALF_W-1:0] h);
    return {{14{h[12]}}, h[12], h[6:2], 12'd0};
  endfunction

  function automatic logic [IMM_W-1:0] imm_spadj(input logic [HALF_W-1:0] h);
    return {{22{h[12]}}, h[12], h[4:3], h[5], h[2], h[6], 4'd0};
  endfunction

  function automatic logic [IMM_W-1:0] imm_branch(input logic [HALF_W-1:0] h);
    return {{23{h[12]}}, h[12], h[6:5], h[2], h[11:10], h[4:3], 1'b0};
  endfunction

  function automatic logic [IMM_W-1:0] imm_jump(input logic [HALF_W-1:0] h);
    return {{20{h[12]}}, h[12], h[8], h[10:9], h[6], h[7], h[2], h[11], h[5:3], 1'b0};
  endfunction

  function automatic logic [IMM_W-1:0] imm_spldw(input logic [HALF_W-1:0] h);
    return {24'd0, h[3:2], h[12], h[6:4], 2'b00};
  endfunction

  function automatic logic [IMM_W-1:0] imm_spldd(input logic [HALF_W-1:0] h);
    return {23'd0, h[4:2], h[12], h[6:5], 3'b000};
  endfunction

  function automatic logic [IMM_W-1:0] imm_spstw(input logic [HALF_W-1:0] h);
    return {24'd0, h[8:7], h[12:9], 2'b00};
  endfunction

  function automatic logic [IMM_W-1:0] imm_spstd(input logic [HALF_W-1:0] h);
    return {23'd0, h[9:7], h[12:10], 3'b000};
  endfunction

endpackage

// File: rtl/rvc_imm_build.sv
module rvc_imm_build
  import rvc_dec_pkg::*;
(
  input  logic [HALF_W-1:0] half,
  input  imm_fmt_e          fmt,
  output logic [IMM_W-1:0]  imm
);

  always_comb begin
    case (fmt)
      IMF_SPADD:  imm = imm_spadd(half);
      IMF_MEMW:   imm = imm_memw(half);
      IMF_MEMD:   imm = imm_memd(half);
      IMF_SMALL:  imm = imm_small(half);
      IMF_SHAMT:  imm = imm_shamt(half);
      IMF_UPPER:  imm = imm_upper(half);
      IMF_SPADJ:  imm = imm_spadj(half);
      IMF_BRANCH: imm = imm_branch(half);
      IMF_JUMP:   imm = imm_jump(half);
      IMF_SPLDW:  imm = imm_spldw(half);
      IMF_SPLDD:  imm = imm_spldd(half);
      IMF_SPSTW:  imm = imm_spstw(half);
      IMF_SPSTD:  imm = imm_spstd(half);
      default:    imm = '0;
    endcase
  end

endmodule

// File: rtl/rvc_op_decode.sv
module rvc_op_decode
  import rvc_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [HALF_W-1:0] half,
  output rvc_op_e           op,
  output logic [REG_W-1:0]  rd,
  output logic [REG_W-1:0]  rs1,
  output logic [REG_W-1:0]  rs2,
  output imm_fmt_e          fmt,
  output logic              illegal
);

  localparam bit WIDE = (XLEN == 64);

  logic [2:0]       fn;
  logic [1:0]       quad;
  logic             b12;
  logic [REG_W-1:0] fld_hi;
  logic [REG_W-1:0] fld_lo;
  logic [REG_W-1:0] nr_hi;
  logic [REG_W-1:0] nr_lo;

  assign fn     = half[15:13];
  assign quad   = half[1:0];
  assign b12    = half[12];
  assign fld_hi = half[11:7];
  assign fld_lo = half[6:2];
  assign nr_hi  = narrow_reg(half[9:7]);
  assign nr_lo  = narrow_reg(half[4:2]);

  rvc_op_e          op_raw;
  logic [REG_W-1:0] rd_raw, rs1_raw, rs2_raw;
  imm_fmt_e         fmt_raw;
  logic             bad;

  always_comb begin
    op_raw  = OPC_ILLEGAL;
    rd_raw  = REG_ZERO;
    rs1_raw = REG_ZERO;
    rs2_raw = REG_ZERO;
    fmt_raw = IMF_NONE;
    bad     = 1'b0;
    case (quad)
      2'b00: begin
        rs1_raw = nr_hi;
        case (fn)
          3'b000: begin
            op_raw = OPC_ADDI4SPN; rd_raw = nr_lo; rs1_raw = REG_SP;
            fmt_raw = IMF_SPADD; bad = (half[12:5] == 8'd0);
          end
          3'b001: begin op_raw = OPC_FLD; rd_raw = nr_lo; fmt_raw = IMF_MEMD; end
          3'b010: begin op_raw = OPC_LW;  rd_raw = nr_lo; fmt_raw = IMF_MEMW; end
          3'b011: begin
            rd_raw = nr_lo;
            op_raw  = WIDE ? OPC_LD : OPC_FLW;
            fmt_raw = WIDE ? IMF_MEMD : IMF_MEMW;
          end
          3'b101: begin op_raw = OPC_FSD; rs2_raw = nr_lo; fmt_raw = IMF_MEMD; end
          3'b110: begin op_raw = OPC_SW;  rs2_raw = nr_lo; fmt_raw = IMF_MEMW; end
          3'b111: begin
            rs2_raw = nr_lo;
            op_raw  = WIDE ? OPC_SD : OPC_FSW;
            fmt_raw = WIDE ? IMF_MEMD : IMF_MEMW;
          end
          default: bad = 1'b1;
        endcase
      end
      2'b01: begin
        case (fn)
          3'b000: begin op_raw = OPC_ADDI; rd_raw = fld_hi; rs1_raw = fld_hi; fmt_raw = IMF_SMALL; end
          3'b001: begin
            if (WIDE) begin
              op_raw = OPC_ADDIW; rd_raw = fld_hi; rs1_raw = fld_hi; fmt_raw = IMF_SMALL;
            end else begin
              op_raw = OPC_JAL; rd_raw = REG_LINK; fmt_raw = IMF_JUMP;
            end
          end
          3'b010: begin op_raw = OPC_LI; rd_raw = fld_hi; fmt_raw = IMF_SMALL; end
          3'b011: begin
            if (fld_hi == REG_SP) begin
              op_raw = OPC_ADDI16SP; rd_raw = REG_SP; rs1_raw = REG_SP; fmt_raw = IMF_SPADJ;
            end else begin
              op_raw = OPC_LUI; rd_raw = fld_hi; fmt_raw = IMF_UPPER;
            end
          end
          3'b100: begin
            rd_raw  = nr_hi;
            rs1_raw = nr_hi;
            case (half[11:10])
              2'b00: begin op_raw = OPC_SRLI; fmt_raw = IMF_SHAMT; bad = !WIDE && b12; end
              2'b01: begin op_raw = OPC_SRAI; fmt_raw = IMF_SHAMT; bad = !WIDE && b12; end
              2'b10: begin op_raw = OPC_ANDI; fmt_raw = IMF_SMALL; end
              default: begin
                rs2_raw = nr_lo;
                case (half[6:5])
                  2'b00:   op_raw = b12 ? OPC_SUBW : OPC_SUB;
                  2'b01:   op_raw = b12 ? OPC_ADDW : OPC_XOR;
                  2'b10:   op_raw = OPC_OR;
                  default: op_raw = OPC_AND;
                endcase
              end
            endcase
          end
          3'b101: begin op_raw = OPC_J; fmt_raw = IMF_JUMP; end
          3'b110: begin op_raw = OPC_BEQZ; rs1_raw = nr_hi; fmt_raw = IMF_BRANCH; end
          default: begin op_raw = OPC_BNEZ; rs1_raw = nr_hi; fmt_raw = IMF_BRANCH; end
        endcase
      end
      2'b10: begin
        case (fn)
          3'b000: begin
            op_raw = OPC_SLLI; rd_raw = fld_hi; rs1_raw = fld_hi;
            fmt_raw = IMF_SHAMT; bad = !WIDE && b12;
          end
          3'b001: begin op_raw = OPC_FLDSP; rd_raw = fld_hi; rs1_raw = REG_SP; fmt_raw = IMF_SPLDD; end
          3'b010: begin
            op_raw = OPC_LWSP; rd_raw = fld_hi; rs1_raw = REG_SP;
            fmt_raw = IMF_SPLDW; bad = (fld_hi == REG_ZERO);
          end
          3'b011: begin
            rd_raw = fld_hi; rs1_raw = REG_SP;
            if (WIDE) begin
              op_raw = OPC_LDSP; fmt_raw = IMF_SPLDD; bad = (fld_hi == REG_ZERO);
            end else begin
              op_raw = OPC_FLWSP; fmt_raw = IMF_SPLDW;
            end
          end
          3'b100: begin
            if (!b12) begin
              if (fld_lo == REG_ZERO) begin
                op_raw = OPC_JR; rs1_raw = fld_hi;
              end else begin
                op_raw = OPC_MV; rd_raw = fld_hi; rs2_raw = fld_lo;
              end
            end else if (half[11:2] == 10'd0) begin
              op_raw = OPC_EBREAK;
            end else if (fld_lo == REG_ZERO) begin
              op_raw = OPC_JALR; rd_raw = REG_LINK; rs1_raw = fld_hi;
            end else begin
              op_raw = OPC_ADD; rd_raw = fld_hi; rs1_raw = fld_hi; rs2_raw = fld_lo;
            end
          end
          3'b101: begin op_raw = OPC_FSDSP; rs1_raw = REG_SP; rs2_raw = fld_lo; fmt_raw = IMF_SPSTD; end
          3'b110: begin op_raw = OPC_SWSP;  rs1_raw = REG_SP; rs2_raw = fld_lo; fmt_raw = IMF_SPSTW; end
          default: begin
            rs1_raw = REG_SP; rs2_raw = fld_lo;
            op_raw  = WIDE ? OPC_SDSP : OPC_FSWSP;
            fmt_raw = WIDE ? IMF_SPSTD : IMF_SPSTW;
          end
        endcase
      end
      default: bad = 1'b1;
    endcase
  end

  assign illegal = bad;
  assign op      = bad ? OPC_ILLEGAL : op_raw;
  assign rd      = bad ? REG_ZERO : rd_raw;
  assign rs1     = bad ? REG_ZERO : rs1_raw;
  assign rs2     = bad ? REG_ZERO : rs2_raw;
  assign fmt     = bad ? IMF_NONE : fmt_raw;

endmodule

// File: rtl/rvc_decoder.sv
module rvc_decoder
  import rvc_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       in_half,
  output logic              out_valid,
  output logic [5:0]        out_op,
  output logic [4:0]        out_rd,
  output logic [4:0]        out_rs1,
  output logic [4:0]        out_rs2,
  output logic [31:0]       out_imm,
  output logic              out_illegal
);

  generate
    if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      initial $error("rvc_decoder: XLEN must be 32 or 64");
    end
  endgenerate

  rvc_op_e          dec_op;
  logic [REG_W-1:0] dec_rd, dec_rs1, dec_rs2;
  imm_fmt_e         dec_fmt;
  logic             dec_bad;
  logic [IMM_W-1:0] dec_imm;

  rvc_op_decode #(.XLEN(XLEN)) u_op (
    .half    (in_half),
    .op      (dec_op),
    .rd      (dec_rd),
    .rs1     (dec_rs1),
    .rs2     (dec_rs2),
    .fmt     (dec_fmt),
    .illegal (dec_bad)
  );

  rvc_imm_build u_imm (
    .half (in_half),
    .fmt  (dec_fmt),
    .imm  (dec_imm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_op      <= OPC_ILLEGAL;
      out_rd      <= '0;
      out_rs1     <= '0;
      out_rs2     <= '0;
      out_imm     <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_op      <= dec_op;
        out_rd      <= dec_rd;
        out_rs1     <= dec_rs1;
        out_rs2     <= dec_rs2;
        out_imm     <= dec_imm;
        out_illegal <= dec_bad;
      end
    end
  end

  // Named events for the properties below
  logic sp_form_out;
  logic q3_in;
  logic spadd_zero_in;
  logic narrow_arith_in;
  assign sp_form_out = out_op inside {OPC_ADDI4SPN, OPC_ADDI16SP, OPC_LWSP, OPC_LDSP,
                                      OPC_FLWSP, OPC_FLDSP, OPC_SWSP, OPC_SDSP,
                                      OPC_FSWSP, OPC_FSDSP};
  assign q3_in           = in_valid && (in_half[1:0] == 2'b11);
  assign spadd_zero_in   = in_valid && (in_half[1:0] == 2'b00) &&
                           (in_half[15:13] == 3'b000) && (in_half[12:5] == 8'd0);
  assign narrow_arith_in = in_valid && (in_half[1:0] == 2'b01) &&
                           (in_half[15:13] == 3'b100) && (in_half[11:10] == 2'b11);

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_op) && $stable(out_imm) && $stable(out_illegal));

  assert_quadrant3_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q3_in |=> out_illegal && out_op == OPC_ILLEGAL && out_imm == '0);

  assert_narrow_regs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_arith_in |=> out_rd[4:3] == 2'b01 && out_rs2[4:3] == 2'b01 && out_rd == out_rs1);

  assert_spadd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spadd_zero_in |=> out_illegal);

  assert_sp_base_R13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && sp_form_out |-> out_rs1 == REG_SP && !out_illegal);

  assert_reset_state_R14: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !out_illegal);

endmodule

// File: tb/rvc_decoder_tb_top.sv
`timescale 1ns/1ps
module rvc_decoder_tb_top;
  import rvc_dec_pkg::*;

  typedef struct {
    logic [5:0]  op;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [31:0] imm;
    logic        ill;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_half = '0;

  logic        v32, i32, v64, i64;
  logic [5:0]  op32, op64;
  logic [4:0]  rd32, rs132, rs232, rd64, rs164, rs264;
  logic [31:0] imm32, imm64;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  exp_t q32[$];
  exp_t q64[$];
  logic [5:0] last_op32 = '0;

  always #2.5 clk = ~clk;

  rvc_decoder #(.XLEN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
    .out_valid(v32), .out_op(op32), .out_rd(rd32), .out_rs1(rs132),
    .out_rs2(rs232), .out_imm(imm32), .out_illegal(i32));

  rvc_decoder #(.XLEN(64)) dut64_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
    .out_valid(v64), .out_op(op64), .out_rd(rd64), .out_rs1(rs164),
    .out_rs2(rs264), .out_imm(imm64), .out_illegal(i64));

  function automatic logic [15:0] mk(input logic [1:0] q, input logic [2:0] f3,
                                     input logic b12, input logic [4:0] hi,
                                     input logic [4:0] lo);
    return {f3, b12, hi, lo, q};
  endfunction

  function automatic exp_t ex(input rvc_op_e op, input int rd, input int rs1,
                              input int rs2, input logic [31:0] imm, input string tag);
    exp_t e;
    e.op = op; e.rd = 5'(rd); e.rs1 = 5'(rs1); e.rs2 = 5'(rs2);
    e.imm = imm; e.ill = 1'b0; e.tag = tag;
    return e;
  endfunction

  function automatic exp_t exbad(input string tag);
    exp_t e;
    e.op = OPC_ILLEGAL; e.rd = '0; e.rs1 = '0; e.rs2 = '0;
    e.imm = '0; e.ill = 1'b1; e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [15:0] h, input exp_t e32, input exp_t e64);
    @(negedge clk);
    in_valid = 1'b1;
    in_half  = h;
    q32.push_back(e32);
    q64.push_back(e64);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    in_half  = 16'hA5A5;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic compare(input string side, input logic [5:0] op, input logic [4:0] rd,
                         input logic [4:0] rs1, input logic [4:0] rs2,
                         input logic [31:0] imm, input logic ill, input exp_t e);
    checks++;
    if (op !== e.op || rd !== e.rd || rs1 !== e.rs1 || rs2 !== e.rs2 ||
        imm !== e.imm || ill !== e.ill) begin
      failures++;
      $display("FAIL %s %s: got op=%0d rd=%0d rs1=%0d rs2=%0d imm=%h ill=%b exp op=%0d rd=%0d rs1=%0d rs2=%0d imm=%h ill=%b",
               e.tag, side, op, rd, rs1, rs2, imm, ill,
               e.op, e.rd, e.rs1, e.rs2, e.imm, e.ill);
    end
  endtask

  // Scoreboard monitor: one popped item per valid result on each width
  always @(posedge clk) begin
    #1;
    if (rst_n && v32) begin
      if (q32.size() == 0) begin
        checks++; failures++;
        $display("FAIL R1 rv32: unexpected valid, got 1 exp 0");
      end else begin
        exp_t e;
        e = q32.pop_front();
        compare("rv32", op32, rd32, rs132, rs232, imm32, i32, e);
        last_op32 = e.op;
      end
    end
    if (rst_n && v64) begin
      if (q64.size() == 0) begin
        checks++; failures++;
        $display("FAIL R1 rv64: unexpected valid, got 1 exp 0");
      end else begin
        exp_t e;
        e = q64.pop_front();
        compare("rv64", op64, rd64, rs164, rs264, imm64, i64, e);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    // R14 reset state
    checks++;
    if (v32 !== 1'b0 || i32 !== 1'b0 || op32 !== 6'(OPC_ILLEGAL)) begin
      failures++;
      $display("FAIL R14: got valid=%b ill=%b op=%0d exp 0 0 %0d", v32, i32, op32, OPC_ILLEGAL);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (v32 !== 1'b0 || v64 !== 1'b0) begin
      failures++;
      $display("FAIL R14: got valid=%b/%b exp 0", v32, v64);
    end

    // R2 illegal encodings
    send(16'h0000, exbad("R2 zero"), exbad("R2 zero"));
    send(16'hFFFF, exbad("R2 quad3"), exbad("R2 quad3"));
    send(mk(2'd0, 3'd4, 1'b0, 5'd0, 5'b00100), exbad("R2 q0f4"), exbad("R2 q0f4"));
    // R7 stack add immediate
    e = ex(OPC_ADDI4SPN, 9, 2, 0, 32'h3FC, "R7 max");
    send(mk(2'd0, 3'd0, 1'b1, 5'd31, 5'b11001), e, e);
    send(mk(2'd0, 3'd0, 1'b0, 5'd0, 5'b00001), exbad("R7 zero"), exbad("R7 zero"));
    // R3 R11 register-based loads/stores
    e = ex(OPC_LW, 10, 11, 0, 32'h7C, "R11 lw");
    send(mk(2'd0, 3'd2, 1'b1, 5'b11011, 5'b11010), e, e);
    send(mk(2'd0, 3'd3, 1'b1, 5'b11001, 5'b11110),
         ex(OPC_FLW, 14, 9, 0, 32'h7C, "R6 flw"), ex(OPC_LD, 14, 9, 0, 32'hF8, "R6 ld"));
    e = ex(OPC_SW, 0, 8, 15, 32'h44, "R3 sw");
    send(mk(2'd0, 3'd6, 1'b0, 5'd0, 5'b11111), e, e);
    send(mk(2'd0, 3'd7, 1'b0, 5'b01000, 5'b10010),
         ex(OPC_FSW, 0, 8, 10, 32'h0C, "R6 fsw"), ex(OPC_SD, 0, 8, 10, 32'h88, "R6 sd"));
    // R9 small immediates
    e = ex(OPC_ADDI, 5, 5, 0, 32'hFFFFFFFF, "R9 addi");
    send(mk(2'd1, 3'd0, 1'b1, 5'd5, 5'd31), e, e);
    send(mk(2'd1, 3'd1, 1'b1, 5'd31, 5'd31),
         ex(OPC_JAL, 1, 0, 0, 32'hFFFFFFFE, "R13 jal"), ex(OPC_ADDIW, 31, 31, 0, 32'hFFFFFFFF, "R6 addiw"));
    e = ex(OPC_LI, 7, 0, 0, 32'd31, "R13 li");
    send(mk(2'd1, 3'd2, 1'b0, 5'd7, 5'd31), e, e);
    // R8 upper / stack adjust
    e = ex(OPC_ADDI16SP, 2, 2, 0, 32'hFFFFFE00, "R8 spadj neg");
    send(mk(2'd1, 3'd3, 1'b1, 5'd2, 5'd0), e, e);
    e = ex(OPC_ADDI16SP, 2, 2, 0, 32'h1F0, "R8 spadj pos");
    send(mk(2'd1, 3'd3, 1'b0, 5'd2, 5'd31), e, e);
    e = ex(OPC_LUI, 3, 0, 0, 32'hFFFE1000, "R8 lui");
    send(mk(2'd1, 3'd3, 1'b1, 5'd3, 5'd1), e, e);
    // R4 arithmetic group
    e = ex(OPC_SRLI, 12, 12, 0, 32'd3, "R4 srli");
    send(mk(2'd1, 3'd4, 1'b0, 5'b00100, 5'd3), e, e);
    send(mk(2'd1, 3'd4, 1'b1, 5'b01100, 5'd1),
         exbad("R9 srai rv32 wide shamt"), ex(OPC_SRAI, 12, 12, 0, 32'd33, "R9 srai"));
    e = ex(OPC_ANDI, 13, 13, 0, 32'hFFFFFFE0, "R4 andi");
    send(mk(2'd1, 3'd4, 1'b1, 5'b10101, 5'd0), e, e);
    e = ex(OPC_SUB, 8, 8, 9, 0, "R4 sub");
    send(mk(2'd1, 3'd4, 1'b0, 5'b11000, 5'b00001), e, e);
    e = ex(OPC_XOR, 10, 10, 11, 0, "R4 xor");
    send(mk(2'd1, 3'd4, 1'b0, 5'b11010, 5'b01011), e, e);
    e = ex(OPC_OR, 12, 12, 13, 0, "R4 or");
    send(mk(2'd1, 3'd4, 1'b0, 5'b11100, 5'b10101), e, e);
    e = ex(OPC_AND, 14, 14, 15, 0, "R4 and");
    send(mk(2'd1, 3'd4, 1'b0, 5'b11110, 5'b11111), e, e);
    e = ex(OPC_SUBW, 9, 9, 10, 0, "R4 subw");
    send(mk(2'd1, 3'd4, 1'b1, 5'b11001, 5'b00010), e, e);
    e = ex(OPC_ADDW, 11, 11, 8, 0, "R4 addw");
    send(mk(2'd1, 3'd4, 1'b1, 5'b11011, 5'b01000), e, e);
    // R10 jumps and branches
    e = ex(OPC_J, 0, 0, 0, 32'h7FE, "R10 j");
    send(mk(2'd1, 3'd5, 1'b0, 5'd31, 5'd31), e, e);
    e = ex(OPC_BEQZ, 0, 14, 0, 32'hFFFFFF00, "R10 beqz");
    send(mk(2'd1, 3'd6, 1'b1, 5'b00110, 5'd0), e, e);
    e = ex(OPC_BNEZ, 0, 8, 0, 32'hFE, "R10 bnez");
    send(mk(2'd1, 3'd7, 1'b0, 5'b11000, 5'd31), e, e);
    // Quadrant 2
    e = ex(OPC_SLLI, 20, 20, 0, 32'd5, "R9 slli");
    send(mk(2'd2, 3'd0, 1'b0, 5'd20, 5'd5), e, e);
    send(mk(2'd2, 3'd0, 1'b1, 5'd20, 5'd0),
         exbad("R9 slli rv32 wide shamt"), ex(OPC_SLLI, 20, 20, 0, 32'd32, "R9 slli64"));
    e = ex(OPC_LWSP, 6, 2, 0, 32'hFC, "R11 lwsp");
    send(mk(2'd2, 3'd2, 1'b1, 5'd6, 5'd31), e, e);
    send(mk(2'd2, 3'd2, 1'b1, 5'd0, 5'd31), exbad("R12 lwsp x0"), exbad("R12 lwsp x0"));
    send(mk(2'd2, 3'd3, 1'b1, 5'd9, 5'd31),
         ex(OPC_FLWSP, 9, 2, 0, 32'hFC, "R6 flwsp"), ex(OPC_LDSP, 9, 2, 0, 32'h1F8, "R6 ldsp"));
    send(mk(2'd2, 3'd3, 1'b0, 5'd0, 5'd0),
         ex(OPC_FLWSP, 0, 2, 0, 32'h0, "R12 flwsp f0"), exbad("R12 ldsp x0"));
    e = ex(OPC_JR, 0, 1, 0, 0, "R5 jr");
    send(mk(2'd2, 3'd4, 1'b0, 5'd1, 5'd0), e, e);
    e = ex(OPC_MV, 10, 0, 11, 0, "R5 mv");
    send(mk(2'd2, 3'd4, 1'b0, 5'd10, 5'd11), e, e);
    e = ex(OPC_EBREAK, 0, 0, 0, 0, "R5 ebreak");
    send(mk(2'd2, 3'd4, 1'b1, 5'd0, 5'd0), e, e);
    e = ex(OPC_JALR, 1, 5, 0, 0, "R5 jalr");
    send(mk(2'd2, 3'd4, 1'b1, 5'd5, 5'd0), e, e);
    e = ex(OPC_FSDSP, 0, 2, 2, 32'h40, "R11 fsdsp");
    send(mk(2'd2, 3'd5, 1'b0, 5'b00001, 5'd2), e, e);
    e = ex(OPC_SWSP, 0, 2, 1, 32'hFC, "R11 swsp");
    send(mk(2'd2, 3'd6, 1'b1, 5'd31, 5'd1), e, e);
    send(mk(2'd2, 3'd7, 1'b1, 5'd31, 5'd3),
         ex(OPC_FSWSP, 0, 2, 3, 32'hFC, "R6 fswsp"), ex(OPC_SDSP, 0, 2, 3, 32'h1F8, "R6 sdsp"));
    e = ex(OPC_ADD, 10, 10, 11, 0, "R5 add");
    send(mk(2'd2, 3'd4, 1'b1, 5'd10, 5'd11), e, e);

    // R1 hold while idle
    idle(4);
    checks++;
    if (v32 !== 1'b0 || op32 !== last_op32 || last_op32 !== 6'(OPC_ADD)) begin
      failures++;
      $display("FAIL R1 hold: got valid=%b op=%0d exp valid=0 op=%0d", v32, op32, OPC_ADD);
    end
    checks++;
    if (q32.size() != 0 || q64.size() != 0) begin
      failures++;
      $display("FAIL R1 drain: got pending=%0d/%0d exp 0/0", q32.size(), q64.size());
    end
    finish_run();
  end

endmodule